// File: doc/BRIEF.md
# Masked Interrupt Merger with Per-Line Event Counters

This block gathers a set of level-sensitive interrupt request lines into a single interrupt signal for a processor. Every line has a sticky pending bit. The pending bit is set whenever the line is high and stays set until software clears it. A mask register chooses which pending bits may raise the output.

Software uses a small register port with a write strobe, a two-bit offset, write data and combinational read data. Through it, software writes and reads the mask, reads the pending bits, and clears them by writing ones. A line that is still high when its bit is cleared sets that bit again at once. Each line also has a 64-bit counter of its assertions. Software reads the low or high half of the counter picked by a separate line-select input.

The register port and the interrupt output are plain control pins, not a data stream. They have no valid/ready handshake and no back-pressure. A write is taken on every clock edge where the strobe is high.

Top module: `irq_merge_ctrl`

## Requirements
- R1: Reset clears the mask, the pending bits, the sampled line levels and every event counter, and drives `irq_out` low. All four offsets read zero while reset is held.
- R2: A write at offset 0 loads `reg_wdata` into the mask on that clock edge. Offset 0 then reads back the new mask.
- R3: A line that is high at a clock edge sets its pending bit at that edge. The bit stays set after the line drops, until it is acknowledged. Offset 1 reads the pending bits, with bit i belonging to line i.
- R4: A write at offset 1 clears every pending bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R5: If a line is high at the edge that acknowledges its pending bit, the bit stays set. This also covers a line that rises in the same cycle as the acknowledge.
- R6: After every edge, `irq_out` is high exactly when the updated pending bits ANDed with the updated mask are nonzero. It therefore follows a line change, mask write or acknowledge by one edge.
- R7: A line's counter increments by one at each edge where the line is high and its previously sampled level was low. A line held high is counted once.
- R8: Offset 2 returns bits 31:0 and offset 3 returns bits 63:32 of the counter chosen by `cnt_sel`.
- R9: Writes at offsets 2 and 3 leave the mask, the pending bits and the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level-sensitive interrupt request lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register offset: 0 mask, 1 pending, 2 counter low, 3 counter high |
| reg_wdata | input | 32 | Write data |
| cnt_sel | input | 5 | Line whose counter is returned at offsets 2 and 3 |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` and `cnt_sel` |
| irq_out | output | 1 | Merged, masked interrupt, registered |

## Verification
Stimulus applied before a rising edge shows at that edge on every result. The mask, the pending bits, the counters and `irq_out` all update there. `reg_rdata` follows the offset and line select within the same cycle, with no extra latency. The bench drives inputs at the falling edge and advances a behavioural model at the rising edge. Half a nanosecond after each falling edge it compares `irq_out` and `reg_rdata` for the current offset against the model, so every result is sampled exactly one edge after its stimulus. Directed steps with fixed expected values cover the sticky, acknowledge, re-arm, same-cycle and counter cases, and a random phase stirs lines, writes and selects.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  // Register offsets on the software port
  localparam logic [1:0] OFS_MASK   = 2'd0;
  localparam logic [1:0] OFS_PEND   = 2'd1;
  localparam logic [1:0] OFS_CNT_LO = 2'd2;
  localparam logic [1:0] OFS_CNT_HI = 2'd3;

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  input  logic [N_LINES-1:0] ack_i,
  output logic [N_LINES-1:0] line_q,
  output logic [N_LINES-1:0] pend_q,
  output logic [N_LINES-1:0] pend_nxt,
  output logic [N_LINES-1:0] rise_o
);

  // Raw level ORed in after the clear: a live line always wins over an ack
  always_comb begin
    pend_nxt = (pend_q & ~ack_i) | lines_i;
    rise_o   = lines_i & ~line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= lines_i;
      pend_q <= pend_nxt;
    end
  end

  AST_LINE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(lines_i)) == $past(lines_i))); // R3

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q) & ~$past(ack_i)) == ($past(pend_q) & ~$past(ack_i)))); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(ack_i) & ~$past(lines_i)) == '0)); // R4

  AST_ACK_LIVE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(ack_i) & $past(lines_i)) == ($past(ack_i) & $past(lines_i)))); // R5

endmodule

// File: rtl/irq_event_counters.sv
module irq_event_counters #(
  parameter int N_LINES = 32,
  parameter int CNT_W   = 64,
  parameter int SEL_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] rise_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [CNT_W-1:0]   sel_cnt_o
);

  logic [CNT_W-1:0] cnt_q [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q[g] <= '0;
      else if (rise_i[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i[g] |=> (cnt_q[g] == $past(cnt_q[g]) + 1'b1)); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_i[g] |=> $stable(cnt_q[g])); // R7
  end

  always_comb begin
    sel_cnt_o = '0;
    if (int'(sel_i) < N_LINES) sel_cnt_o = cnt_q[sel_i];
  end

endmodule

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
  import irq_merge_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [N_LINES-1:0] pend_q_i,
  input  logic [N_LINES-1:0] pend_nxt_i,
  input  logic [CNT_W-1:0]   sel_cnt_i,
  output logic [N_LINES-1:0] ack_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);

  localparam int HI_W = CNT_W - DATA_W;

  logic [N_LINES-1:0] mask_q, mask_nxt;
  logic               irq_q;
  logic               wr_mask, wr_pend;

  always_comb begin
    wr_mask  = wr_i && (addr_i == OFS_MASK);
    wr_pend  = wr_i && (addr_i == OFS_PEND);
    mask_nxt = wr_mask ? wdata_i[N_LINES-1:0] : mask_q;
    ack_o    = wr_pend ? wdata_i[N_LINES-1:0] : '0;
  end

  // Output decided from the post-edge state so it never lags a cycle more
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      irq_q  <= |(pend_nxt_i & mask_nxt);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_MASK:   rdata_o[N_LINES-1:0] = mask_q;
      OFS_PEND:   rdata_o[N_LINES-1:0] = pend_q_i;
      OFS_CNT_LO: rdata_o = sel_cnt_i[DATA_W-1:0];
      OFS_CNT_HI: rdata_o[HI_W-1:0] = sel_cnt_i[CNT_W-1:DATA_W];
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wdata_i[N_LINES-1:0]))); // R2

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(pend_q_i & mask_q))); // R6

  AST_CNT_OFS_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i[1]) |=> $stable(mask_q)); // R9

endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl #(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 64,
  localparam int SEL_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [SEL_W-1:0]   cnt_sel,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_out
);

  logic [N_LINES-1:0] line_q, pend_q, pend_nxt, rise, ack;
  logic [CNT_W-1:0]   sel_cnt;

  irq_line_bank #(.N_LINES(N_LINES)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_i  (irq_in),
    .ack_i    (ack),
    .line_q   (line_q),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt),
    .rise_o   (rise)
  );

  irq_event_counters #(.N_LINES(N_LINES), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnts (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise),
    .sel_i     (cnt_sel),
    .sel_cnt_o (sel_cnt)
  );

  irq_csr_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .pend_q_i   (pend_q),
    .pend_nxt_i (pend_nxt),
    .sel_cnt_i  (sel_cnt),
    .ack_o      (ack),
    .rdata_o    (reg_rdata),
    .irq_o      (irq_out)
  );

  AST_RISE_COUNTED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0)); // R7

  AST_IRQ_LOW_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !irq_out); // R1

endmodule

// File: tb/irq_merge_ctrl_test.sv
module irq_merge_ctrl_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [4:0]  cnt_sel = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_merge_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cnt_sel(cnt_sel),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // Behavioural reference model
  logic [31:0]     m_mask = '0, m_pend = '0, m_line = '0;
  logic            m_irq = 1'b0;
  longint unsigned m_cnt [32];

  initial for (int i = 0; i < 32; i++) m_cnt[i] = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_pend = '0; m_line = '0; m_irq = 1'b0;
      for (int i = 0; i < 32; i++) m_cnt[i] = 0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (reg_wr && reg_addr == 2'd1 && reg_wdata[i]) m_pend[i] = 1'b0;
        if (irq_in[i]) m_pend[i] = 1'b1;
        if (irq_in[i] && !m_line[i]) m_cnt[i] = m_cnt[i] + 1;
      end
      if (reg_wr && reg_addr == 2'd0) m_mask = reg_wdata;
      m_line = irq_in;
      m_irq = ((m_pend & m_mask) != 0);
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a, input logic [4:0] s);
    case (a)
      2'd0:    return m_mask;
      2'd1:    return m_pend;
      2'd2:    return m_cnt[s][31:0];
      default: return m_cnt[s][63:32];
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    #0.5;
    check(irq_out == m_irq, "R6 irq_out vs model", 32'(irq_out), 32'(m_irq));
    check(reg_rdata == m_read(reg_addr, cnt_sel),
          reg_addr == 2'd0 ? "R2 mask readback" : reg_addr == 2'd1 ? "R3 R4 pending readback" : "R8 counter readback",
          reg_rdata, m_read(reg_addr, cnt_sel));
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [4:0] s, input logic [31:0] exp, input string tag);
    reg_addr = a; cnt_sel = s;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic peek_irq(input logic exp, input string tag);
    #1;
    check(irq_out == exp, tag, 32'(irq_out), 32'(exp));
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    peek(2'd0, 5'd0, 32'h0, "R1 mask in reset");
    peek(2'd1, 5'd0, 32'h0, "R1 pending in reset");
    peek(2'd2, 5'd3, 32'h0, "R1 counter lo in reset");
    peek_irq(1'b0, "R1 irq_out in reset");
    step();
    rst_n = 1'b1;

    wr(2'd0, 32'h0000_00F0);
    peek(2'd0, 5'd0, 32'h0000_00F0, "R2 mask loaded");

    step(); irq_in[0] = 1'b1;
    step(); irq_in[0] = 1'b0;
    peek(2'd1, 5'd0, 32'h0000_0001, "R3 pending from masked line");
    peek_irq(1'b0, "R6 masked pending keeps irq low");
    irq_in[4] = 1'b1;
    step();
    peek(2'd1, 5'd0, 32'h0000_0011, "R3 pending set");
    peek_irq(1'b1, "R6 unmasked pending raises irq");
    peek(2'd2, 5'd4, 32'd1, "R7 first rise counted");
    irq_in[4] = 1'b0;
    step();
    peek(2'd1, 5'd0, 32'h0000_0011, "R3 pending sticky after drop");

    wr(2'd1, 32'h0000_0010);
    peek(2'd1, 5'd0, 32'h0000_0001, "R4 write-one clears only written bits");
    peek_irq(1'b0, "R6 irq drops after ack");

    irq_in[5] = 1'b1;
    wr(2'd1, 32'h0000_0020);
    peek(2'd1, 5'd0, 32'h0000_0021, "R5 live line re-sets pending");
    peek_irq(1'b1, "R6 irq stays with live line");
    repeat (5) step();
    peek(2'd2, 5'd5, 32'd1, "R7 held line counted once");
    irq_in[5] = 1'b0;
    wr(2'd1, 32'h0000_0020);
    peek(2'd1, 5'd0, 32'h0000_0001, "R4 ack after line drop");

    irq_in[6] = 1'b1;
    step(); irq_in[6] = 1'b0;
    step();
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0040; irq_in[6] = 1'b1;
    step();
    reg_wr = 1'b0;
    peek(2'd1, 5'd0, 32'h0000_0041, "R5 same-cycle rise beats ack");
    peek(2'd2, 5'd6, 32'd2, "R7 second rise counted");
    irq_in[6] = 1'b0;

    for (int k = 0; k < 3; k++) begin
      step(); irq_in[7] = 1'b1;
      step(); irq_in[7] = 1'b0;
    end
    step();
    peek(2'd2, 5'd7, 32'd3, "R8 counter low half");
    peek(2'd3, 5'd7, 32'd0, "R8 counter high half");

    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    peek(2'd0, 5'd0, 32'h0000_00F0, "R9 mask untouched");
    peek(2'd1, 5'd0, 32'h0000_00C1, "R9 pending untouched");
    peek(2'd2, 5'd7, 32'd3, "R9 counter untouched");
    peek_irq(1'b1, "R6 irq before mask clear");

    wr(2'd0, 32'h0);
    peek_irq(1'b0, "R2 R6 mask clear drops irq");

    for (int c = 0; c < 400; c++) begin
      step();
      irq_in    = irq_in ^ ($urandom & $urandom & $urandom);
      reg_wr    = ($urandom % 3) == 0;
      reg_addr  = 2'($urandom % 4);
      reg_wdata = $urandom;
      cnt_sel   = 5'($urandom % 32);
    end
    step();
    reg_wr = 1'b0;
    rst_n = 1'b0;
    step();
    peek(2'd1, 5'd0, 32'h0, "R1 pending cleared by reset");
    peek(2'd2, 5'd7, 32'h0, "R1 counter cleared by reset");
    peek(2'd0, 5'd0, 32'h0, "R1 mask cleared by reset");
    peek_irq(1'b0, "R1 irq low after reset");
    step();
    rst_n = 1'b1;
    irq_in = '0;
    repeat (2) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule